// File: doc/BRIEF.md
# Message and Doorbell Interrupt Unit

This block is a small register file that lets a host bus master and a local processor signal each other. In each direction there are two 32-bit message registers and one doorbell register. Writing a message register raises a status bit on the receiving side. Writing a doorbell sets pending bits, and the receiver clears them by writing them back. Each side has its own status word and its own mask word. One interrupt line per direction is asserted while any status bit that is not masked is set.

Both sides share one 32-bit register port. A side-select bit on that port marks each access as coming from the host or from the local processor, and that side decides which writes take effect. Queue machinery outside this block reports its post-queue events, overflow events and machine-check events through one-cycle event inputs, and these are latched here as status. A read never changes state; only writes clear status and doorbell bits.

Top module: `msgdb_irq_unit`

## Requirements
- R1: Word addresses 0 and 1 are the two inbound message registers. Only a host-side write (side=0) stores into them. Word addresses 2 and 3 are the two outbound message registers. Only a local-side write (side=1) stores into them. Any side can read all four, and writes from the other side are ignored.
- R2: A stored message write to inbound register k sets inbound status bit k (k=0,1). A stored write to outbound register k sets outbound status bit k.
- R3: Address 4 is the inbound doorbell. A host write sets the bits that are 1 in the data. A local write clears the bits that are 1 in the data.
- R4: Address 5 is the outbound doorbell. A local write sets only the data bits within 28:0, so bits 31:29 are never set. A host write clears the bits that are 1 in the data.
- R5: Status bit 3 of each direction reads 1 exactly while that direction's doorbell has any bit set. A status write does not change it.
- R6: Event inputs set sticky status bits. Inbound: machine-check sets bit 4, post-queue sets bit 5, inbound-post overflow sets bit 7 and outbound-free overflow sets bit 8. Outbound: post-queue sets bit 5. A set in the same cycle as a clear wins.
- R7: The inbound status (address 6) is cleared by a local write and the outbound status (address 8) by a host write. Each bit written as 1 is cleared. Writes from the other side are ignored.
- R8: The inbound mask (address 7) is written by the local side and holds bits 0,1,3,4,5,7,8. The outbound mask (address 9) is written by the host and holds bits 0,1,3,5. Undefined bits read 0. A 1 disables the source. After reset every defined mask bit is 1, so the masks read 0x1BB and 0x02B.
- R9: irq_in is the OR of inbound status AND NOT mask, and irq_out is the same for the outbound direction. Each takes the new value in the cycle after the clock edge that registers a write or event.
- R10: A read has no side effects. Addresses 10 to 15 read 0, and writes to them change nothing. rd_data is 0 whenever no read is requested.
- R11: After reset all message, doorbell and status bits are 0, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_side | input | 1 | 0 = host, 1 = local processor |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, same cycle as the request |
| in_postq_evt | input | 1 | Inbound post-queue event |
| out_postq_evt | input | 1 | Outbound post-queue event |
| mchk_evt | input | 1 | Machine-check event |
| in_post_ovf_evt | input | 1 | Inbound-post queue overflow event |
| out_free_ovf_evt | input | 1 | Outbound-free queue overflow event |
| irq_in | output | 1 | Interrupt to the local processor |
| irq_out | output | 1 | Interrupt to the host |

## Verification
Every piece of state can be read back, and it also feeds an interrupt line that is compared on every clock. A wrong status, mask or doorbell bit therefore shows on irq_in or irq_out in the cycle after the faulty edge, provided the source is unmasked. It also shows on the next read of that register. The random phase clears the masks often, and it mixes writes from both sides with writes from the wrong side, so an ignored write that took effect is seen at the next read. Directed steps cover reset values, the reserved outbound doorbell bits, and an event that arrives together with a clear.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int DATA_W  = 32;
    localparam int STAT_W  = 9;
    localparam int NUM_MSG = 2;

    localparam int B_MSG0  = 0;
    localparam int B_MSG1  = 1;
    localparam int B_DB    = 3;
    localparam int B_MCHK  = 4;
    localparam int B_POSTQ = 5;
    localparam int B_IPOVF = 7;
    localparam int B_OFOVF = 8;

    localparam logic [STAT_W-1:0] IN_VALID   = 9'h1BB;
    localparam logic [STAT_W-1:0] OUT_VALID  = 9'h02B;
    localparam logic [STAT_W-1:0] IN_STICKY  = 9'h1B3;
    localparam logic [STAT_W-1:0] OUT_STICKY = 9'h023;

    localparam logic [DATA_W-1:0] IN_DB_SET  = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] OUT_DB_SET = 32'h1FFF_FFFF;

    typedef enum logic [3:0] {
        A_IMSG0 = 4'd0,
        A_IMSG1 = 4'd1,
        A_OMSG0 = 4'd2,
        A_OMSG1 = 4'd3,
        A_IDB   = 4'd4,
        A_ODB   = 4'd5,
        A_ISTAT = 4'd6,
        A_IMASK = 4'd7,
        A_OSTAT = 4'd8,
        A_OMASK = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/mdu_msg_bank.sv
module mdu_msg_bank #(
    parameter int NMSG = 2,
    parameter int DW   = 32,
    localparam int IW  = (NMSG > 1) ? $clog2(NMSG) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    output logic [NMSG-1:0][DW-1:0]  regs_o,
    output logic [NMSG-1:0]          wr_hit_o
);
    typedef struct packed {
        logic [NMSG-1:0][DW-1:0] msg;
    } bank_t;

    bank_t state_d, state_q;

    for (genvar k = 0; k < NMSG; k++) begin : g_hit
        assign wr_hit_o[k] = wr_en && (wr_idx == IW'(k));
    end

    always_comb begin
        state_d = state_q;
        for (int k = 0; k < NMSG; k++) begin
            if (wr_hit_o[k]) state_d.msg[k] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign regs_o = state_q.msg;

    // R1
    msg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_o[$past(wr_idx)] == $past(wr_data));

    // R1
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));
endmodule

// File: rtl/mdu_doorbell.sv
module mdu_doorbell #(
    parameter int DW = 32,
    parameter logic [DW-1:0] SET_MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] bits_o,
    output logic          pend_o
);
    typedef struct packed {
        logic [DW-1:0] bits;
    } db_t;

    db_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_en)      state_d.bits = state_q.bits | (wdata & SET_MASK);
        else if (clr_en) state_d.bits = state_q.bits & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bits_o = state_q.bits;
    assign pend_o = |state_q.bits;

    // R4
    db_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((bits_o & ~$past(bits_o)) & ~SET_MASK) == '0);

    // R3
    db_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (bits_o & $past(wdata) & SET_MASK) == ($past(wdata) & SET_MASK));

    // R3
    db_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> (bits_o & $past(wdata)) == '0);
endmodule

// File: rtl/mdu_irq_ctrl.sv
module mdu_irq_ctrl #(
    parameter int SW = 9,
    parameter logic [SW-1:0] VALID  = '1,
    parameter logic [SW-1:0] STICKY = '1,
    parameter int DB_BIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_i,
    input  logic          clr_en,
    input  logic          mask_en,
    input  logic [SW-1:0] wdata,
    input  logic          db_pend,
    output logic [SW-1:0] stat_o,
    output logic [SW-1:0] mask_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [SW-1:0] stat;
        logic [SW-1:0] mask;
    } ctl_t;

    ctl_t state_d, state_q;
    logic [SW-1:0] clr_vec;
    logic [SW-1:0] db_vec;

    always_comb begin
        state_d = state_q;
        clr_vec = clr_en ? wdata : '0;
        state_d.stat = ((state_q.stat & ~clr_vec) | set_i) & STICKY;
        if (mask_en) state_d.mask = wdata & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.stat <= '0;
            state_q.mask <= VALID;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        db_vec = '0;
        db_vec[DB_BIT] = db_pend;
    end

    assign stat_o = state_q.stat | db_vec;
    assign mask_o = state_q.mask;
    assign irq_o  = |(stat_o & ~state_q.mask & VALID);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & STICKY)) |=> (stat_o & $past(set_i & STICKY)) == $past(set_i & STICKY));

    // R10
    stat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && set_i == '0) |=> (stat_o & STICKY) == $past(stat_o & STICKY));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_en |=> $stable(mask_o));

    // R7
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (stat_o & $past(wdata & ~set_i) & STICKY) == '0);
endmodule

// File: rtl/msgdb_irq_unit.sv
module msgdb_irq_unit
    import mdu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_side,
    input  logic [3:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] rd_data,
    input  logic        in_postq_evt,
    input  logic        out_postq_evt,
    input  logic        mchk_evt,
    input  logic        in_post_ovf_evt,
    input  logic        out_free_ovf_evt,
    output logic        irq_in,
    output logic        irq_out
);
    localparam int IW = (NUM_MSG > 1) ? $clog2(NUM_MSG) : 1;

    logic wr_host, wr_local, rd_any;
    logic imsg_wr, omsg_wr;
    logic idb_set, idb_clr, odb_set, odb_clr;
    logic ist_clr, imask_wr, ost_clr, omask_wr;
    logic [STAT_W-1:0] in_set, out_set;

    logic [NUM_MSG-1:0][DATA_W-1:0] in_msgs, out_msgs;
    logic [NUM_MSG-1:0] in_hit, out_hit;
    logic [DATA_W-1:0] idb_bits, odb_bits;
    logic idb_pend, odb_pend;
    logic [STAT_W-1:0] in_stat, in_mask, out_stat, out_mask;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        wr_host  = req_valid && req_write && !req_side;
        wr_local = req_valid && req_write &&  req_side;
        rd_any   = req_valid && !req_write;
        imsg_wr  = wr_host  && (req_addr == A_IMSG0 || req_addr == A_IMSG1);
        omsg_wr  = wr_local && (req_addr == A_OMSG0 || req_addr == A_OMSG1);
        idb_set  = wr_host  && (req_addr == A_IDB);
        idb_clr  = wr_local && (req_addr == A_IDB);
        odb_set  = wr_local && (req_addr == A_ODB);
        odb_clr  = wr_host  && (req_addr == A_ODB);
        ist_clr  = wr_local && (req_addr == A_ISTAT);
        imask_wr = wr_local && (req_addr == A_IMASK);
        ost_clr  = wr_host  && (req_addr == A_OSTAT);
        omask_wr = wr_host  && (req_addr == A_OMASK);
    end

    always_comb begin
        in_set           = '0;
        in_set[B_MSG0]   = in_hit[0];
        in_set[B_MSG1]   = in_hit[1];
        in_set[B_MCHK]   = mchk_evt;
        in_set[B_POSTQ]  = in_postq_evt;
        in_set[B_IPOVF]  = in_post_ovf_evt;
        in_set[B_OFOVF]  = out_free_ovf_evt;
        out_set          = '0;
        out_set[B_MSG0]  = out_hit[0];
        out_set[B_MSG1]  = out_hit[1];
        out_set[B_POSTQ] = out_postq_evt;
    end

    mdu_msg_bank #(.NMSG(NUM_MSG), .DW(DATA_W)) u_in_msgs (
        .clk(clk), .rst_n(rst_n), .wr_en(imsg_wr), .wr_idx(req_addr[IW-1:0]),
        .wr_data(req_wdata), .regs_o(in_msgs), .wr_hit_o(in_hit)
    );

    mdu_msg_bank #(.NMSG(NUM_MSG), .DW(DATA_W)) u_out_msgs (
        .clk(clk), .rst_n(rst_n), .wr_en(omsg_wr), .wr_idx(req_addr[IW-1:0]),
        .wr_data(req_wdata), .regs_o(out_msgs), .wr_hit_o(out_hit)
    );

    mdu_doorbell #(.DW(DATA_W), .SET_MASK(IN_DB_SET)) u_in_db (
        .clk(clk), .rst_n(rst_n), .set_en(idb_set), .clr_en(idb_clr),
        .wdata(req_wdata), .bits_o(idb_bits), .pend_o(idb_pend)
    );

    mdu_doorbell #(.DW(DATA_W), .SET_MASK(OUT_DB_SET)) u_out_db (
        .clk(clk), .rst_n(rst_n), .set_en(odb_set), .clr_en(odb_clr),
        .wdata(req_wdata), .bits_o(odb_bits), .pend_o(odb_pend)
    );

    mdu_irq_ctrl #(.SW(STAT_W), .VALID(IN_VALID), .STICKY(IN_STICKY), .DB_BIT(B_DB)) u_in_ctl (
        .clk(clk), .rst_n(rst_n), .set_i(in_set), .clr_en(ist_clr), .mask_en(imask_wr),
        .wdata(req_wdata[STAT_W-1:0]), .db_pend(idb_pend),
        .stat_o(in_stat), .mask_o(in_mask), .irq_o(irq_in)
    );

    mdu_irq_ctrl #(.SW(STAT_W), .VALID(OUT_VALID), .STICKY(OUT_STICKY), .DB_BIT(B_DB)) u_out_ctl (
        .clk(clk), .rst_n(rst_n), .set_i(out_set), .clr_en(ost_clr), .mask_en(omask_wr),
        .wdata(req_wdata[STAT_W-1:0]), .db_pend(odb_pend),
        .stat_o(out_stat), .mask_o(out_mask), .irq_o(irq_out)
    );

    always_comb begin
        rd_val = '0;
        case (req_addr)
            A_IMSG0: rd_val = in_msgs[0];
            A_IMSG1: rd_val = in_msgs[1];
            A_OMSG0: rd_val = out_msgs[0];
            A_OMSG1: rd_val = out_msgs[1];
            A_IDB:   rd_val = idb_bits;
            A_ODB:   rd_val = odb_bits;
            A_ISTAT: rd_val = DATA_W'(in_stat);
            A_IMASK: rd_val = DATA_W'(in_mask);
            A_OSTAT: rd_val = DATA_W'(out_stat);
            A_OMASK: rd_val = DATA_W'(out_mask);
            default: rd_val = '0;
        endcase
        rd_data = rd_any ? rd_val : '0;
    end

    // R5
    db_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|idb_bits) && !in_mask[B_DB]) |-> irq_in);

    // R5
    odb_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|odb_bits) && !out_mask[B_DB]) |-> irq_out);

    // R2
    msg_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imsg_wr |=> in_stat[$past(req_addr[0])]);

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |-> rd_data == '0);
endmodule

// File: tb/tb_msgdb_irq_unit.sv
module tb_msgdb_irq_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_side = 1'b0;
    logic [3:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic in_postq_evt = 1'b0, out_postq_evt = 1'b0, mchk_evt = 1'b0;
    logic in_post_ovf_evt = 1'b0, out_free_ovf_evt = 1'b0;
    logic irq_in, irq_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference model
    logic [31:0] m_im [2];
    logic [31:0] m_om [2];
    logic [31:0] m_idb, m_odb;
    logic [8:0]  m_ist, m_ost, m_imask, m_omask;

    always #2 clk = ~clk;

    msgdb_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_side(req_side), .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .in_postq_evt(in_postq_evt), .out_postq_evt(out_postq_evt), .mchk_evt(mchk_evt),
        .in_post_ovf_evt(in_post_ovf_evt), .out_free_ovf_evt(out_free_ovf_evt),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] full_ist();
        return m_ist | ((m_idb != 0) ? 9'h008 : 9'h000);
    endfunction

    function automatic logic [8:0] full_ost();
        return m_ost | ((m_odb != 0) ? 9'h008 : 9'h000);
    endfunction

    function automatic logic [31:0] model_read(logic [3:0] a);
        case (a)
            4'd0: return m_im[0];
            4'd1: return m_im[1];
            4'd2: return m_om[0];
            4'd3: return m_om[1];
            4'd4: return m_idb;
            4'd5: return m_odb;
            4'd6: return {23'd0, full_ist()};
            4'd7: return {23'd0, m_imask};
            4'd8: return {23'd0, full_ost()};
            4'd9: return {23'd0, m_omask};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string read_tag(logic [3:0] a);
        if (a < 4) return "R1";
        if (a == 4) return "R3";
        if (a == 5) return "R4";
        if (a == 6 || a == 8) return "R7";
        if (a == 7 || a == 9) return "R8";
        return "R10";
    endfunction

    task automatic model_reset();
        m_im[0] = 0; m_im[1] = 0; m_om[0] = 0; m_om[1] = 0;
        m_idb = 0; m_odb = 0; m_ist = 0; m_ost = 0;
        m_imask = 9'h1BB; m_omask = 9'h02B;
    endtask

    // events: {ofovf, ipovf, mchk, opostq, ipostq}
    task automatic step(bit v, bit w, bit s, logic [3:0] a, logic [31:0] d,
                        logic [4:0] ev, string tag);
        logic [31:0] exp_rd;
        @(negedge clk);
        req_valid = v; req_write = w; req_side = s; req_addr = a; req_wdata = d;
        in_postq_evt = ev[0]; out_postq_evt = ev[1]; mchk_evt = ev[2];
        in_post_ovf_evt = ev[3]; out_free_ovf_evt = ev[4];
        #1;
        exp_rd = (v && !w) ? model_read(a) : 32'd0;
        check((tag != "") ? tag : ((v && !w) ? read_tag(a) : "R10"), rd_data, exp_rd);
        @(posedge clk);
        if (v && w) begin
            if (!s) begin
                if (a < 2) begin m_im[a[0]] = d; m_ist[a[0]] = 1'b1; end
                if (a == 4) m_idb = m_idb | d;
                if (a == 5) m_odb = m_odb & ~d;
                if (a == 8) m_ost = m_ost & ~d[8:0];
                if (a == 9) m_omask = d[8:0] & 9'h02B;
            end else begin
                if (a == 2 || a == 3) begin m_om[a[0]] = d; m_ost[a[0]] = 1'b1; end
                if (a == 4) m_idb = m_idb & ~d;
                if (a == 5) m_odb = m_odb | (d & 32'h1FFF_FFFF);
                if (a == 6) m_ist = m_ist & ~d[8:0];
                if (a == 7) m_imask = d[8:0] & 9'h1BB;
            end
        end
        m_ist = (m_ist | {ev[4], ev[3], 1'b0, ev[0], ev[2], 4'b0}) & 9'h1B3;
        m_ost = (m_ost | {3'b0, ev[1], 5'b0}) & 9'h023;
        #1;
        check("R9", {31'd0, irq_in},  {31'd0, |(full_ist() & ~m_imask)});
        check("R9", {31'd0, irq_out}, {31'd0, |(full_ost() & ~m_omask)});
    endtask

    task automatic rd(logic [3:0] a, string tag);
        step(1, 0, 0, a, 32'd0, 5'd0, tag);
    endtask

    task automatic wr(bit s, logic [3:0] a, logic [31:0] d);
        step(1, 1, s, a, d, 5'd0, "");
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        check("R11", {30'd0, irq_in, irq_out}, 32'd0);
        for (int a = 0; a < 16; a++) rd(4'(a), "R11");

        // R1 / R2 message path
        wr(0, 4'd1, 32'hCAFE_0001);
        rd(4'd1, "R1");
        rd(4'd6, "R2");
        wr(1, 4'd0, 32'h1111_2222);          // wrong side: ignored
        rd(4'd0, "R1");
        wr(1, 4'd2, 32'hBEEF_0002);
        rd(4'd8, "R2");
        wr(1, 4'd7, 32'h0);                  // unmask all inbound
        wr(0, 4'd9, 32'h0);

        // R3 / R5 inbound doorbell
        wr(0, 4'd4, 32'h8000_0011);
        rd(4'd6, "R5");
        wr(1, 4'd6, 32'h0000_0008);          // status write cannot clear doorbell bit
        rd(4'd6, "R5");
        wr(1, 4'd4, 32'h0000_0010);
        rd(4'd4, "R3");
        wr(1, 4'd4, 32'h8000_0001);
        rd(4'd6, "R5");

        // R4 reserved outbound doorbell bits
        wr(1, 4'd5, 32'hFFFF_FFFF);
        rd(4'd5, "R4");
        wr(0, 4'd5, 32'h0FFF_FFFF);
        rd(4'd5, "R4");
        wr(0, 4'd5, 32'hFFFF_FFFF);

        // R6 events, set wins over clear
        step(1, 1, 1, 4'd6, 32'h0000_01FF, 5'b10101, "");
        rd(4'd6, "R6");
        step(1, 1, 0, 4'd8, 32'h0000_0020, 5'b00010, "");
        rd(4'd8, "R6");
        step(0, 0, 0, 4'd0, 32'd0, 5'b01000, "");
        rd(4'd6, "R6");

        // R7 wrong-side status clear ignored, then proper clear
        wr(0, 4'd6, 32'h1FF);
        rd(4'd6, "R7");
        wr(1, 4'd6, 32'h1FF);
        wr(0, 4'd8, 32'h1FF);
        rd(4'd6, "R7");

        // R8 masks, undefined bits read 0
        wr(1, 4'd7, 32'hFFFF_FFFF);
        rd(4'd7, "R8");
        wr(1, 4'd9, 32'h0);                  // wrong side
        rd(4'd9, "R8");

        // R10 unmapped writes and reads
        wr(0, 4'd12, 32'hFFFF_FFFF);
        wr(1, 4'd15, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) rd(4'(a), "R10");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] d;
            logic [4:0] ev;
            bit v, w;
            v = ($urandom % 8) != 0;
            w = ($urandom % 5) < 3;
            d = $urandom;
            if ($urandom % 2) d = d & $urandom;
            for (int e = 0; e < 5; e++) ev[e] = ($urandom % 16) == 0;
            step(v, w, 1'($urandom), 4'($urandom % 12), d, ev, "");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule